// File: doc/BRIEF.md
# Period-List Playback DMA Sequencer

This block feeds one audio playback channel from memory. Software places a table of descriptors in memory. Each 8-byte entry names one period of the audio buffer: its first word is the period's start address, and its second word carries the period length in bytes in bits 31:16. The sequencer reads an entry and pulls that period in fixed 64-byte read bursts. It streams the returned words into the output FIFO in order, then moves to the next entry. After the last entry it wraps back to the first one.

The current position is visible at all times through two pointers. The entry pointer is the byte offset of the current entry in the table. The period pointer is the count of bytes already written for that period. A one-cycle pulse marks the middle and the end of every period. Two more pulses mark the middle and the end of the whole buffer.

A stop address with an enable flag lets playback halt at a chosen point inside a period. A sticky flag records any FIFO underrun after streaming has begun. The memory side is a plain request/acknowledge read port with in-order data beats.

Top module: `pdma_seq_top`

## Requirements
- R1: After reset, all outputs are 0: `rd_req`, `fifo_wr`, both pointers, the four event pulses, `active`, `halted` and `underrun`.
- R2: While idle, setting bit CHAN (default 0) of `start_mask` starts a run. Starting clears both pointers, raises `active`, and requests a 2-word read at `list_base + list_ptr`. The other bits of `start_mask` are ignored.
- R3: Word 0 of an entry is the period address. Bits 31:16 of word 1 are the period size in bytes, a nonzero multiple of 64. Each period is read in 16-word bursts at `period address + in_ptr`, and every returned word is written to the FIFO in arrival order.
- R4: A burst is requested only when `fifo_room` is at least 16. No burst is requested while `fifo_room` is 15 or less.
- R5: `in_ptr` is the number of bytes written in the current period, and it returns to 0 when the period completes. `list_ptr` is the byte offset of the current entry. It steps by 8 and returns to 0 after the entry whose offset equals `list_last[21:16]`.
- R6: `ev_half_period` pulses for one cycle when `in_ptr` first shows half the period size.
- R7: `ev_full_period` pulses as `in_ptr` returns to 0 at a period's end. With N = `list_last[21:19]` + 1 entries, `ev_half_buffer` pulses with it at the end of entry N/2−1 (integer division), and `ev_full_buffer` pulses with it at the end of entry N−1.
- R8: If `end_cfg[16]` is 1 and a burst ends with the period byte count equal to `end_cfg[15:0]` (a multiple of 64), the block raises `halted` and issues no further request or write. It stays there until the start bit is cleared, and then returns to idle. With `end_cfg[16]` = 0 that address has no effect.
- R9: `underrun` is set when `fifo_empty` is high during a run after at least one word of that run has been written. It stays set until the next start, which clears it.
- R10: Clearing the start bit lets any read already requested complete. The block then goes idle (`active` = 0) and issues no new request.
- R11: A read request holds `rd_req`, `rd_addr` and `rd_words` steady until the cycle `rd_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_mask | input | 4 | One start bit per channel; bit CHAN runs this block |
| list_base | input | 32 | Byte address of the descriptor table |
| list_last | input | 32 | Byte offset of the last entry, in bits 21:16 |
| end_cfg | input | 17 | Stop address [15:0] and stop enable [16] |
| rd_req | output | 1 | Read request |
| rd_addr | output | 32 | Read byte address |
| rd_words | output | 5 | Words requested (2 or 16) |
| rd_ack | input | 1 | Request accepted |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| fifo_room | input | 8 | Free words in the output FIFO |
| fifo_empty | input | 1 | Output FIFO is empty |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 32 | FIFO write data |
| list_ptr | output | 6 | Byte offset of the current entry |
| in_ptr | output | 16 | Bytes written in the current period |
| ev_half_period | output | 1 | Half-period pulse |
| ev_full_period | output | 1 | Period-end pulse |
| ev_half_buffer | output | 1 | Half-buffer pulse |
| ev_full_buffer | output | 1 | Buffer-end pulse |
| active | output | 1 | A run is in progress (including halted) |
| halted | output | 1 | Stopped at the stop address |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
The hardest cases to reach are the ones where several things must line up at one beat. One is the buffer wrap, where the last entry's end pulses the period and buffer events together and the entry pointer returns to 0. Another is a halt that lands in the middle of a period. The stimulus reaches them with short tables whose periods take only one or two bursts. The tables are run several times around, and the stop address is placed on a burst boundary inside the first period. Underrun has to be shown to need a prior write, so the FIFO room is held below one burst while the FIFO reports empty, and is released only after the descriptor read.

// File: rtl/pdma_pkg.sv
// Shared types for the period-list playback sequencer.
package pdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DREQ,
        S_DRSP,
        S_BWAIT,
        S_BREQ,
        S_BRSP,
        S_HALT
    } seq_state_t;
endpackage

// File: rtl/pdma_seq_fsm.sv
// Fetch controller: reads one descriptor, then issues bursts for that period
// until the position tracker reports the period complete or the stop point.
// Assumes in-order read beats and one outstanding request at a time.
module pdma_seq_fsm
    import pdma_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int LPTR_W      = 6,
    parameter int PPTR_W      = 16,
    parameter int ROOM_W      = 8,
    parameter int BURST_WORDS = 16,
    parameter int DESC_WORDS  = 2,
    parameter int CNT_W       = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [LPTR_W-1:0] list_ptr,
    input  logic [PPTR_W-1:0] in_ptr,
    input  logic [ROOM_W-1:0] fifo_room,
    input  logic              period_done,
    input  logic              stop_hit,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_words,
    input  logic              rd_ack,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [PPTR_W-1:0] period_size,
    output logic              start_pulse,
    output logic              active,
    output logic              halted
);
    localparam logic [CNT_W-1:0] LAST_BURST = CNT_W'(BURST_WORDS - 1);
    localparam logic [CNT_W-1:0] LAST_DESC  = CNT_W'(DESC_WORDS - 1);

    seq_state_t        st, st_nx;
    logic [CNT_W-1:0]  beat;
    logic [ADDR_W-1:0] period_addr;
    logic              room_ok;
    logic              burst_end;

    assign room_ok   = fifo_room >= ROOM_W'(BURST_WORDS);
    assign burst_end = (st == S_BRSP) && rd_valid && (beat == LAST_BURST);

    // Next-state selection for the descriptor/burst sequence
    always_comb begin
        st_nx = st;
        case (st)
            S_IDLE:  if (run_en) st_nx = S_DREQ;
            S_DREQ:  if (rd_ack) st_nx = S_DRSP;
            S_DRSP:  if (rd_valid && beat == LAST_DESC)
                         st_nx = run_en ? S_BWAIT : S_IDLE;
            S_BWAIT: begin
                if (!run_en)      st_nx = S_IDLE;
                else if (room_ok) st_nx = S_BREQ;
            end
            S_BREQ:  if (rd_ack) st_nx = S_BRSP;
            S_BRSP:  if (burst_end) begin
                if (stop_hit)         st_nx = S_HALT;
                else if (!run_en)     st_nx = S_IDLE;
                else if (period_done) st_nx = S_DREQ;
                else                  st_nx = S_BWAIT;
            end
            S_HALT:  if (!run_en) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Beat counter within the current response
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (rd_ack)
            beat <= '0;
        else if (rd_valid && (st == S_DRSP || st == S_BRSP))
            beat <= beat + 1'b1;
    end

    // Capture descriptor words: address then size in the upper halfword
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_addr <= '0;
            period_size <= '0;
        end else if (st == S_DRSP && rd_valid) begin
            if (beat == '0) period_addr <= rd_data[ADDR_W-1:0];
            else            period_size <= rd_data[DATA_W-1 -: PPTR_W];
        end
    end

    // Request port drive
    always_comb begin
        rd_req   = (st == S_DREQ) || (st == S_BREQ);
        rd_addr  = (st == S_DREQ) ? list_base + ADDR_W'(list_ptr)
                                  : period_addr + ADDR_W'(in_ptr);
        rd_words = (st == S_DREQ) ? CNT_W'(DESC_WORDS) : CNT_W'(BURST_WORDS);
    end

    assign fifo_wr     = (st == S_BRSP) && rd_valid;
    assign fifo_wdata  = rd_data;
    assign start_pulse = (st == S_IDLE) && run_en;
    assign active      = (st != S_IDLE);
    assign halted      = (st == S_HALT);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_words));
    // R4
    room_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) && rd_words == CNT_W'(BURST_WORDS) |-> $past(fifo_room) >= ROOM_W'(BURST_WORDS));
    // R8
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !rd_req && !fifo_wr);
endmodule

// File: rtl/pdma_pos_track.sv
// Position tracker: keeps the in-period byte count and the entry offset,
// flags the write that completes a period or reaches the stop address, and
// emits registered period/buffer event pulses aligned with the pointers.
// Assumes period sizes are nonzero multiples of the burst size.
module pdma_pos_track #(
    parameter int LPTR_W  = 6,
    parameter int PPTR_W  = 16,
    parameter int WORD_B  = 4,
    parameter int ENTRY_B = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [PPTR_W-1:0] period_size,
    input  logic [LPTR_W-1:0] last_off,
    input  logic [PPTR_W-1:0] end_addr,
    input  logic              stop_en,
    output logic [PPTR_W-1:0] in_ptr,
    output logic [LPTR_W-1:0] list_ptr,
    output logic              period_done,
    output logic              stop_hit,
    output logic              ev_half_period,
    output logic              ev_full_period,
    output logic              ev_half_buffer,
    output logic              ev_full_buffer
);
    localparam int SH    = $clog2(ENTRY_B);
    localparam int IDX_W = LPTR_W - SH;

    logic [PPTR_W-1:0] in_inc;
    logic [IDX_W:0]    n_entries;
    logic [IDX_W-1:0]  half_idx;
    logic              at_last;

    assign in_inc      = in_ptr + PPTR_W'(WORD_B);
    assign period_done = wr && (in_inc == period_size);
    assign stop_hit    = wr && stop_en && (in_inc == end_addr);
    assign at_last     = (list_ptr == last_off);
    assign n_entries   = {1'b0, last_off[LPTR_W-1:SH]} + 1'b1;
    assign half_idx    = IDX_W'((n_entries >> 1) - 1'b1);

    // In-period byte counter
    always_ff @(posedge clk) begin
        if (!rst_n || start) in_ptr <= '0;
        else if (wr)         in_ptr <= period_done ? '0 : in_inc;
    end

    // Entry offset with wrap after the last entry
    always_ff @(posedge clk) begin
        if (!rst_n || start)  list_ptr <= '0;
        else if (period_done) list_ptr <= at_last ? '0 : list_ptr + LPTR_W'(ENTRY_B);
    end

    // Event pulses, registered to line up with the updated pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_half_period <= 1'b0;
            ev_full_period <= 1'b0;
            ev_half_buffer <= 1'b0;
            ev_full_buffer <= 1'b0;
        end else begin
            ev_half_period <= wr && (in_inc == (period_size >> 1));
            ev_full_period <= period_done;
            ev_half_buffer <= period_done && (list_ptr[LPTR_W-1:SH] == half_idx);
            ev_full_buffer <= period_done && at_last;
        end
    end

    // R7
    fullbuf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full_buffer |-> ev_full_period && list_ptr == '0);
    // R7
    halfbuf_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_half_buffer |-> ev_full_period);
    // R5
    period_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_full_period |-> in_ptr == '0);
    // R6
    halfp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_half_period |-> in_ptr == (period_size >> 1));
endmodule

// File: rtl/pdma_xrun_mon.sv
// Underrun monitor: arms on the first FIFO write of a run and latches a
// sticky flag if the FIFO reports empty while the run is still active.
module pdma_xrun_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wr,
    input  logic active,
    input  logic fifo_empty,
    output logic underrun
);
    logic primed;

    // Arm after the first word of a run
    always_ff @(posedge clk) begin
        if (!rst_n || start) primed <= 1'b0;
        else if (wr)         primed <= 1'b1;
    end

    // Sticky underrun flag
    always_ff @(posedge clk) begin
        if (!rst_n || start)                   underrun <= 1'b0;
        else if (active && primed && fifo_empty) underrun <= 1'b1;
    end

    // R9
    xrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(fifo_empty) && $past(active));
endmodule

// File: rtl/pdma_seq_top.sv
// Period-list playback DMA sequencer top: joins the fetch controller, the
// position tracker and the underrun monitor for one playback channel.
// Assumes the start field carries one bit per channel and CHAN selects ours.
module pdma_seq_top #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NCH         = 4,
    parameter int CHAN        = 0,
    parameter int LPTR_W      = 6,
    parameter int PPTR_W      = 16,
    parameter int ROOM_W      = 8,
    parameter int BURST_BYTES = 64,
    parameter int ENTRY_B     = 8,
    parameter int WORD_B      = DATA_W / 8,
    parameter int BURST_WORDS = BURST_BYTES / WORD_B,
    parameter int CNT_W       = $clog2(BURST_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    start_mask,
    input  logic [ADDR_W-1:0] list_base,
    input  logic [DATA_W-1:0] list_last,
    input  logic [PPTR_W:0]   end_cfg,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_words,
    input  logic              rd_ack,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ROOM_W-1:0] fifo_room,
    input  logic              fifo_empty,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic [LPTR_W-1:0] list_ptr,
    output logic [PPTR_W-1:0] in_ptr,
    output logic              ev_half_period,
    output logic              ev_full_period,
    output logic              ev_half_buffer,
    output logic              ev_full_buffer,
    output logic              active,
    output logic              halted,
    output logic              underrun
);
    localparam int DESC_WORDS = ENTRY_B / WORD_B;

    logic              run_en;
    logic              start_pulse;
    logic              period_done;
    logic              stop_hit;
    logic [PPTR_W-1:0] period_size;

    assign run_en = start_mask[CHAN];

    pdma_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LPTR_W(LPTR_W), .PPTR_W(PPTR_W),
        .ROOM_W(ROOM_W), .BURST_WORDS(BURST_WORDS), .DESC_WORDS(DESC_WORDS),
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
        .list_ptr(list_ptr), .in_ptr(in_ptr), .fifo_room(fifo_room),
        .period_done(period_done), .stop_hit(stop_hit),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_words(rd_words),
        .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .period_size(period_size),
        .start_pulse(start_pulse), .active(active), .halted(halted)
    );

    pdma_pos_track #(
        .LPTR_W(LPTR_W), .PPTR_W(PPTR_W), .WORD_B(WORD_B), .ENTRY_B(ENTRY_B)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .wr(fifo_wr),
        .period_size(period_size), .last_off(list_last[16 +: LPTR_W]),
        .end_addr(end_cfg[PPTR_W-1:0]), .stop_en(end_cfg[PPTR_W]),
        .in_ptr(in_ptr), .list_ptr(list_ptr), .period_done(period_done),
        .stop_hit(stop_hit), .ev_half_period(ev_half_period),
        .ev_full_period(ev_full_period), .ev_half_buffer(ev_half_buffer),
        .ev_full_buffer(ev_full_buffer)
    );

    pdma_xrun_mon u_xrun (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .wr(fifo_wr),
        .active(active), .fifo_empty(fifo_empty), .underrun(underrun)
    );
endmodule

// File: tb/sim_pdma_seq_top.sv
`timescale 1ns/1ps
module sim_pdma_seq_top;
    localparam logic [31:0] LIST_BASE = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  start_mask = 4'b0;
    logic [31:0] list_last = 32'h0;
    logic [16:0] end_cfg = 17'h0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic [4:0]  rd_words;
    logic        rd_ack = 1'b0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = 32'h0;
    logic [7:0]  fifo_room = 8'd64;
    logic        fifo_empty = 1'b0;
    logic        fifo_wr;
    logic [31:0] fifo_wdata;
    logic [5:0]  list_ptr;
    logic [15:0] in_ptr;
    logic        ev_half_period, ev_full_period, ev_half_buffer, ev_full_buffer;
    logic        active, halted, underrun;

    pdma_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .start_mask(start_mask), .list_base(LIST_BASE),
        .list_last(list_last), .end_cfg(end_cfg), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_words(rd_words), .rd_ack(rd_ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .fifo_room(fifo_room),
        .fifo_empty(fifo_empty), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .list_ptr(list_ptr), .in_ptr(in_ptr), .ev_half_period(ev_half_period),
        .ev_full_period(ev_full_period), .ev_half_buffer(ev_half_buffer),
        .ev_full_buffer(ev_full_buffer), .active(active), .halted(halted),
        .underrun(underrun)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int d_addr [8];
    int d_size [8];
    int n_ent = 2;
    int m_in = 0, m_list = 0;
    bit st_en = 0;
    int st_addr = 0;
    bit exp_hp = 0, exp_fp = 0, exp_hb = 0, exp_fb = 0;
    int n_wr = 0, n_fb = 0, n_hb = 0;
    int desc_reqs = 0, burst_reqs = 0;
    bit mon_en = 0, rnd_room = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [31:0] memval(input logic [31:0] a);
        int e;
        if (a >= LIST_BASE && a < LIST_BASE + 64) begin
            e = int'((a - LIST_BASE) >> 3);
            if (a[2]) return {d_size[e][15:0], 16'h0};
            return d_addr[e];
        end
        return pat(a);
    endfunction

    // Memory responder: acknowledges with random delay, returns beats with gaps
    initial begin
        logic [31:0] a;
        int w, dly;
        forever begin
            @(negedge clk);
            if (rd_req) begin
                a = rd_addr;
                w = int'(rd_words);
                dly = $urandom_range(0, 2);
                repeat (dly) begin
                    @(negedge clk);
                    chk(rd_req && rd_addr == a && int'(rd_words) == w, "R11", rd_addr, a);
                end
                rd_ack = 1'b1;
                if (w == 2) begin
                    desc_reqs++;
                    chk(a == LIST_BASE + m_list, "R2", a, LIST_BASE + m_list);
                end else begin
                    burst_reqs++;
                    chk(w == 16 && a == d_addr[m_list >> 3] + m_in, "R3", a, d_addr[m_list >> 3] + m_in);
                end
                @(negedge clk);
                rd_ack = 1'b0;
                for (int i = 0; i < w; i++) begin
                    if ($urandom_range(0, 3) == 0) @(negedge clk);
                    rd_valid = 1'b1;
                    rd_data = memval(a + 32'(4 * i));
                    @(negedge clk);
                    rd_valid = 1'b0;
                end
            end
        end
    end

    // Random FIFO room for stall coverage
    initial begin
        forever begin
            @(negedge clk);
            if (rnd_room) fifo_room = 8'($urandom_range(4, 40));
        end
    end

    // Monitor: compares pointers/events with the model, then applies this cycle's write
    initial begin
        int e, inc;
        forever begin
            @(negedge clk);
            #1;
            if (mon_en) begin
                chk(ev_half_period == exp_hp, "R6", ev_half_period, exp_hp);
                chk({ev_full_period, ev_half_buffer, ev_full_buffer} == {exp_fp, exp_hb, exp_fb},
                    "R7", {ev_full_period, ev_half_buffer, ev_full_buffer}, {exp_fp, exp_hb, exp_fb});
                if (active)
                    chk(int'(in_ptr) == m_in && int'(list_ptr) == m_list, "R5",
                        {list_ptr, in_ptr}, {m_list[5:0], m_in[15:0]});
                n_fb += int'(ev_full_buffer);
                n_hb += int'(ev_half_buffer);
                exp_hp = 0; exp_fp = 0; exp_hb = 0; exp_fb = 0;
                if (fifo_wr) begin
                    e = m_list >> 3;
                    chk(fifo_wdata == pat(d_addr[e] + m_in), "R3", fifo_wdata, pat(d_addr[e] + m_in));
                    inc = m_in + 4;
                    exp_hp = (inc == d_size[e] / 2);
                    if (inc == d_size[e]) begin
                        exp_fp = 1;
                        exp_hb = (e == n_ent / 2 - 1);
                        exp_fb = (e == n_ent - 1);
                        m_in = 0;
                        m_list = exp_fb ? 0 : m_list + 8;
                    end else begin
                        m_in = inc;
                    end
                    n_wr++;
                end
            end
        end
    end

    task automatic setup(input int nent, input bit stp, input int ea);
        n_ent = nent; m_in = 0; m_list = 0; st_en = stp; st_addr = ea;
        n_wr = 0; n_fb = 0; n_hb = 0; desc_reqs = 0; burst_reqs = 0;
        list_last = 32'((nent - 1) * 8) << 16;
        end_cfg = {stp, ea[15:0]};
    endtask

    task automatic wait_writes(input int target);
        for (int c = 0; c < 30000 && n_wr < target && !halted; c++) @(negedge clk);
    endtask

    task automatic stop_run();
        start_mask = 4'b0;
        for (int c = 0; c < 3000 && active; c++) @(negedge clk);
        @(negedge clk);
        chk(!active, "R10", active, 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "R10 watchdog", 0, 1);
        report();
    end

    initial begin
        int tot, rq;
        void'($urandom(32'd12345));
        for (int i = 0; i < 8; i++) begin
            d_addr[i] = 32'h0001_0000 + i * 32'h1000;
            d_size[i] = 64;
        end
        repeat (5) @(negedge clk);
        #1;
        // R1: reset state
        chk({rd_req, fifo_wr, list_ptr, in_ptr} == '0, "R1", {rd_req, fifo_wr, list_ptr, in_ptr}, 0);
        chk({ev_half_period, ev_full_period, ev_half_buffer, ev_full_buffer, active, halted, underrun} == '0,
            "R1", {ev_half_period, ev_full_period, ev_half_buffer, ev_full_buffer, active, halted, underrun}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;

        // R2: start bits of other channels are ignored
        setup(2, 0, 0);
        start_mask = 4'b1110;
        repeat (30) @(negedge clk);
        chk(desc_reqs == 0 && !active, "R2", desc_reqs, 0);
        start_mask = 4'b0;

        // R4 / R9: no burst with room 15; empty FIFO before any write sets no underrun
        setup(2, 0, 0);
        fifo_room = 8'd15;
        fifo_empty = 1'b1;
        @(negedge clk);
        start_mask = 4'b0001;
        repeat (60) @(negedge clk);
        chk(burst_reqs == 0, "R4", burst_reqs, 0);
        chk(desc_reqs == 1, "R2", desc_reqs, 1);
        chk(!underrun, "R9", underrun, 0);
        fifo_room = 8'd16;
        wait_writes(32);
        repeat (3) @(negedge clk);
        chk(underrun, "R9", underrun, 1);
        chk(n_fb == 1 && n_hb == 1, "R7", n_fb, 1);
        stop_run();
        fifo_empty = 1'b0;
        fifo_room = 8'd64;

        // Directed: two entries, three trips round the table
        d_size[0] = 128; d_size[1] = 64;
        setup(2, 0, 0);
        @(negedge clk);
        start_mask = 4'b0001;
        wait_writes(144);
        repeat (2) @(negedge clk);
        chk(n_fb == 3 && n_hb == 3, "R7", {n_fb, n_hb}, {32'd3, 32'd3});
        chk(!underrun, "R9", underrun, 0);
        stop_run();

        // Random: five entries, random sizes and FIFO room
        tot = 0;
        for (int i = 0; i < 5; i++) begin
            d_size[i] = 64 * $urandom_range(1, 4);
            tot += d_size[i];
        end
        setup(5, 0, 0);
        rnd_room = 1;
        @(negedge clk);
        start_mask = 4'b0001;
        wait_writes(2 * tot / 4);
        repeat (2) @(negedge clk);
        chk(n_fb == 2 && n_hb == 2, "R7", {n_fb, n_hb}, {32'd2, 32'd2});
        stop_run();

        // R8: stop flag set at byte 128 of the first period
        for (int i = 0; i < 8; i++) d_size[i] = 256;
        setup(8, 1, 128);
        @(negedge clk);
        start_mask = 4'b0001;
        wait_writes(100000);
        repeat (2) @(negedge clk);
        chk(halted, "R8", halted, 1);
        chk(n_wr == 32 && in_ptr == 16'd128 && list_ptr == 6'd0, "R8", {n_wr, 16'(in_ptr)}, {32'd32, 16'd128});
        rq = desc_reqs + burst_reqs;
        repeat (40) @(negedge clk);
        chk(n_wr == 32 && desc_reqs + burst_reqs == rq, "R8", n_wr, 32);
        stop_run();
        chk(!halted, "R8", halted, 0);

        // R8: same address with the flag clear has no effect
        setup(8, 0, 128);
        @(negedge clk);
        start_mask = 4'b0001;
        wait_writes(512);
        repeat (2) @(negedge clk);
        chk(!halted && n_wr == 512, "R8", n_wr, 512);
        chk(n_fb == 1 && n_hb == 1, "R7", {n_fb, n_hb}, {32'd1, 32'd1});
        stop_run();
        rnd_room = 0;

        repeat (5) @(negedge clk);
        report();
    end
endmodule